// File: doc/BRIEF.md
# Timed ONU Sleep-Mode Controller

This block drives the power state of an optical network unit's data path. Upstream logic parses each received frame header and presents a valid strobe with a sleep flag. When a sleep request arrives while the unit is fully on, the controller runs a fixed excursion. It first enters a short Sleep transition, then a long Low-Power Idle phase with the data path switched off, then a Wake transition. After Wake it returns to Active. Each phase length is given in nanoseconds and converted to clock cycles from a clock-frequency parameter. With the defaults at 125 MHz, Sleep is 360 cycles, Low-Power Idle is 4960 cycles and Wake is 560 cycles, so a full excursion lasts 47.04 µs.

The controller drives two outputs to the rest of the data path. The power-enable output switches the data path on and off. The traffic-hold output tells traffic sources to hold back while the path is unavailable.

The controller also keeps a saturating residency counter for each state, so the share of time spent in each state can be read directly. A separate saturating counter records sleep requests that arrived while an excursion was already running and were therefore ignored. A synchronous clear input zeroes all of these counters.

Top module: `onu_doze_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the outputs are as follows: `state_code` is 0 (Active), `pwr_en` is 1, `traffic_hold` is 0, and every residency counter and `drop_cnt` read zero.
- R2: `state_code` encodes Active=0, Sleep=1, Low-Power Idle=2 and Wake=3. The only state changes are 0→1, 1→2, 2→3 and 3→0.
- R3: After Sleep is entered, `state_code` reads 1 for exactly ceil(CLK_MHZ·SLEEP_NS/1000) cycles, which is 360 with the defaults.
- R4: Low-Power Idle lasts exactly ceil(CLK_MHZ·LPI_NS/1000) cycles, which is 4960 with the defaults. Wake lasts exactly ceil(CLK_MHZ·WAKE_NS/1000) cycles, which is 560 with the defaults. Wake is then followed by Active.
- R5: A request is a cycle with `hdr_valid`=1 and `hdr_sleep`=1. A request sampled in Active moves the controller to Sleep on that clock edge. `hdr_valid` alone, or `hdr_sleep` alone, leaves the controller in Active.
- R6: `pwr_en` is 0 only in Low-Power Idle. `traffic_hold` is 1 in Sleep, Low-Power Idle and Wake, and 0 in Active.
- R7: A request sampled in any state other than Active does not change the state sequence or its timing. Each such request adds one to `drop_cnt`, which saturates at all ones.
- R8: On each clock edge, the residency counter of the state held before that edge increases by one. Each residency counter saturates at all ones.
- R9: `stats_clr` zeroes all four residency counters and `drop_cnt` on the next edge. It takes precedence over any increment on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Parsed header present this cycle |
| hdr_sleep | input | 1 | Sleep request flag of the parsed header |
| stats_clr | input | 1 | Synchronous clear of all counters |
| state_code | output | 2 | Current state (0 Active, 1 Sleep, 2 Low-Power Idle, 3 Wake) |
| pwr_en | output | 1 | Data path power enable |
| traffic_hold | output | 1 | Hold traffic toward the data path |
| res_active | output | CNT_W | Cycles spent in Active |
| res_sleep | output | CNT_W | Cycles spent in Sleep |
| res_lpi | output | CNT_W | Cycles spent in Low-Power Idle |
| res_wake | output | CNT_W | Cycles spent in Wake |
| drop_cnt | output | DROP_W | Requests ignored outside Active |

## Verification
Two pairs of events can fall on the same clock edge, and the bench provokes both.

The first pair is a clear and a counter increment. The clear is asserted on the same edge as the request that starts an excursion. The Active residency counter must read zero afterwards, not one.

The second pair is a dropped request and a state change. Requests are placed on the last cycle of Sleep, of Low-Power Idle and of Wake. In each case the phase must still end on time and Active must follow Wake. The drop counter must rise by exactly one for each of these requests.

// File: rtl/onu_doze_pkg.sv
package onu_doze_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_DOZE   = 2'd1,
        ST_QUIET  = 2'd2,
        ST_RESUME = 2'd3
    } doze_st_e;

    localparam int unsigned N_STATES = 4;

    typedef struct packed {
        logic pwr_en;
        logic hold;
    } rail_ctl_t;

    // Phase length in cycles, rounded up so a phase never runs short.
    function automatic int unsigned ns_to_cycles(int unsigned mhz, int unsigned ns);
        return (mhz * ns + 999) / 1000;
    endfunction

    function automatic doze_st_e next_phase(doze_st_e s);
        case (s)
            ST_ACTIVE: return ST_DOZE;
            ST_DOZE:   return ST_QUIET;
            ST_QUIET:  return ST_RESUME;
            default:   return ST_ACTIVE;
        endcase
    endfunction

    function automatic rail_ctl_t rail_of(doze_st_e s);
        rail_ctl_t r;
        r.pwr_en = (s != ST_QUIET);
        r.hold   = (s != ST_ACTIVE);
        return r;
    endfunction

endpackage

// File: rtl/onu_doze_satcnt.sv
module onu_doze_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && cnt != TOP)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/onu_doze_fsm.sv
module onu_doze_fsm
    import onu_doze_pkg::*;
#(
    parameter int unsigned SLEEP_CYC = 360,
    parameter int unsigned LPI_CYC   = 4960,
    parameter int unsigned WAKE_CYC  = 560
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    output doze_st_e state,
    output logic     drop
);
    localparam int unsigned MAX_SW = (SLEEP_CYC > WAKE_CYC) ? SLEEP_CYC : WAKE_CYC;
    localparam int unsigned MAX_CYC = (LPI_CYC > MAX_SW) ? LPI_CYC : MAX_SW;
    localparam int TW = $clog2(MAX_CYC + 1);

    logic [TW-1:0] tmr;
    logic [TW-1:0] last;

    always_comb begin
        case (state)
            ST_DOZE:   last = TW'(SLEEP_CYC - 1);
            ST_QUIET:  last = TW'(LPI_CYC - 1);
            ST_RESUME: last = TW'(WAKE_CYC - 1);
            default:   last = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ACTIVE;
            tmr   <= '0;
        end else if (state == ST_ACTIVE) begin
            tmr <= '0;
            if (req)
                state <= ST_DOZE;
        end else if (tmr == last) begin
            tmr   <= '0;
            state <= next_phase(state);
        end else begin
            tmr <= tmr + 1'b1;
        end
    end

    assign drop = req && (state != ST_ACTIVE);
endmodule

// File: rtl/onu_doze_resid.sv
module onu_doze_resid
    import onu_doze_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               clr,
    input  doze_st_e                           state,
    output logic [N_STATES-1:0][CNT_W-1:0]     res
);
    for (genvar i = 0; i < N_STATES; i++) begin : g_res
        onu_doze_satcnt #(.W(CNT_W)) cnt_i (
            .clk (clk),
            .rst (rst),
            .clr (clr),
            .inc (state == doze_st_e'(i)),
            .cnt (res[i])
        );
    end
endmodule

// File: rtl/onu_doze_ctrl.sv
module onu_doze_ctrl
    import onu_doze_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 125,
    parameter int unsigned SLEEP_NS = 2880,
    parameter int unsigned LPI_NS   = 39680,
    parameter int unsigned WAKE_NS  = 4480,
    parameter int          CNT_W    = 32,
    parameter int          DROP_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_valid,
    input  logic              hdr_sleep,
    input  logic              stats_clr,
    output logic [1:0]        state_code,
    output logic              pwr_en,
    output logic              traffic_hold,
    output logic [CNT_W-1:0]  res_active,
    output logic [CNT_W-1:0]  res_sleep,
    output logic [CNT_W-1:0]  res_lpi,
    output logic [CNT_W-1:0]  res_wake,
    output logic [DROP_W-1:0] drop_cnt
);
    localparam int unsigned SLEEP_CYC = ns_to_cycles(CLK_MHZ, SLEEP_NS);
    localparam int unsigned LPI_CYC   = ns_to_cycles(CLK_MHZ, LPI_NS);
    localparam int unsigned WAKE_CYC  = ns_to_cycles(CLK_MHZ, WAKE_NS);

    doze_st_e  st;
    logic      req;
    logic      drop;
    rail_ctl_t rail;
    logic [N_STATES-1:0][CNT_W-1:0] res;

    assign req = hdr_valid && hdr_sleep;

    onu_doze_fsm #(
        .SLEEP_CYC (SLEEP_CYC),
        .LPI_CYC   (LPI_CYC),
        .WAKE_CYC  (WAKE_CYC)
    ) fsm_i (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .state (st),
        .drop  (drop)
    );

    onu_doze_resid #(.CNT_W(CNT_W)) resid_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (stats_clr),
        .state (st),
        .res   (res)
    );

    onu_doze_satcnt #(.W(DROP_W)) drop_i (
        .clk (clk),
        .rst (rst),
        .clr (stats_clr),
        .inc (drop),
        .cnt (drop_cnt)
    );

    assign rail         = rail_of(st);
    assign pwr_en       = rail.pwr_en;
    assign traffic_hold = rail.hold;
    assign state_code   = st;
    assign res_active   = res[ST_ACTIVE];
    assign res_sleep    = res[ST_DOZE];
    assign res_lpi      = res[ST_QUIET];
    assign res_wake     = res[ST_RESUME];
endmodule

// File: rtl/onu_doze_chk.sv
module onu_doze_chk #(
    parameter int unsigned SLEEP_CYC = 360,
    parameter int unsigned LPI_CYC   = 4960,
    parameter int unsigned WAKE_CYC  = 560,
    parameter int          CNT_W     = 32,
    parameter int          DROP_W    = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              hdr_valid,
    input logic              hdr_sleep,
    input logic              stats_clr,
    input logic [1:0]        state_code,
    input logic              pwr_en,
    input logic              traffic_hold,
    input logic [CNT_W-1:0]  res_active,
    input logic [CNT_W-1:0]  res_sleep,
    input logic [CNT_W-1:0]  res_lpi,
    input logic [CNT_W-1:0]  res_wake,
    input logic [DROP_W-1:0] drop_cnt
);
    localparam int RW = $clog2(LPI_CYC + 2) + 1;
    localparam logic [RW-1:0] RMAX = {RW{1'b1}};

    logic       req;
    logic [1:0] prev_st;
    logic [RW-1:0] run;

    assign req = hdr_valid && hdr_sleep;

    // Length of the run of prev_st that ended at the last edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_st <= 2'd0;
            run     <= '0;
        end else begin
            prev_st <= state_code;
            if (state_code != prev_st)
                run <= RW'(1);
            else if (run != RMAX)
                run <= run + 1'b1;
        end
    end

    p_order_r2: assert property (@(posedge clk) disable iff (rst)
        (state_code != $past(state_code)) |-> (state_code == $past(state_code) + 2'd1));

    p_sleep_len_r3: assert property (@(posedge clk) disable iff (rst)
        (state_code != prev_st && prev_st == 2'd1) |-> (run == RW'(SLEEP_CYC)));

    p_lpi_len_r4: assert property (@(posedge clk) disable iff (rst)
        (state_code != prev_st && prev_st == 2'd2) |-> (run == RW'(LPI_CYC)));

    p_wake_len_r4: assert property (@(posedge clk) disable iff (rst)
        (state_code != prev_st && prev_st == 2'd3) |-> (run == RW'(WAKE_CYC)));

    p_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (state_code == 2'd0) |=> (state_code == ($past(req) ? 2'd1 : 2'd0)));

    p_rails_r6: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |-> (traffic_hold && state_code == 2'd2));

    p_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (req && state_code != 2'd0 && !stats_clr && drop_cnt != {DROP_W{1'b1}})
        |=> (drop_cnt == $past(drop_cnt) + 1'b1));

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        stats_clr |=> (res_active == '0 && res_sleep == '0 && res_lpi == '0
                       && res_wake == '0 && drop_cnt == '0));
endmodule

bind onu_doze_ctrl onu_doze_chk #(
    .SLEEP_CYC (SLEEP_CYC),
    .LPI_CYC   (LPI_CYC),
    .WAKE_CYC  (WAKE_CYC),
    .CNT_W     (CNT_W),
    .DROP_W    (DROP_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .hdr_valid    (hdr_valid),
    .hdr_sleep    (hdr_sleep),
    .stats_clr    (stats_clr),
    .state_code   (state_code),
    .pwr_en       (pwr_en),
    .traffic_hold (traffic_hold),
    .res_active   (res_active),
    .res_sleep    (res_sleep),
    .res_lpi      (res_lpi),
    .res_wake     (res_wake),
    .drop_cnt     (drop_cnt)
);

// File: tb/onu_doze_ctrl_tb_top.sv
module onu_doze_ctrl_tb_top;
    localparam int CLK_PERIOD = 8;
    localparam int CW = 12;
    localparam int DW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hdr_valid = 1'b0;
    logic hdr_sleep = 1'b0;
    logic stats_clr = 1'b0;
    logic [1:0]    state_code;
    logic          pwr_en, traffic_hold;
    logic [CW-1:0] res_active, res_sleep, res_lpi, res_wake;
    logic [DW-1:0] drop_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    onu_doze_ctrl #(.CNT_W(CW), .DROP_W(DW)) dut_i (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_sleep(hdr_sleep),
        .stats_clr(stats_clr), .state_code(state_code), .pwr_en(pwr_en),
        .traffic_hold(traffic_hold), .res_active(res_active), .res_sleep(res_sleep),
        .res_lpi(res_lpi), .res_wake(res_wake), .drop_cnt(drop_cnt)
    );

    typedef struct packed {
        int        k;
        logic [1:0] st;
        logic      pwr;
        logic      hold;
        int        ac;
        int        sl;
        int        lp;
        int        wk;
        int        dr;
        logic      req;
    } vec_t;

    // k = clock edges since the edge that sampled the opening request.
    localparam int NV = 11;
    localparam vec_t VEC [0:NV-1] = '{
        '{1,    2'd1, 1'b1, 1'b1, 0, 0,   0,    0,   0, 1'b0},
        '{360,  2'd1, 1'b1, 1'b1, 0, 359, 0,    0,   0, 1'b1},
        '{361,  2'd2, 1'b0, 1'b1, 0, 360, 0,    0,   1, 1'b0},
        '{362,  2'd2, 1'b0, 1'b1, 0, 360, 1,    0,   1, 1'b0},
        '{4455, 2'd2, 1'b0, 1'b1, 0, 360, 4094, 0,   1, 1'b0},
        '{4456, 2'd2, 1'b0, 1'b1, 0, 360, 4095, 0,   1, 1'b0},
        '{5320, 2'd2, 1'b0, 1'b1, 0, 360, 4095, 0,   1, 1'b1},
        '{5321, 2'd3, 1'b1, 1'b1, 0, 360, 4095, 0,   2, 1'b0},
        '{5880, 2'd3, 1'b1, 1'b1, 0, 360, 4095, 559, 2, 1'b1},
        '{5881, 2'd0, 1'b1, 1'b0, 0, 360, 4095, 560, 3, 1'b0},
        '{5882, 2'd0, 1'b1, 1'b0, 1, 360, 4095, 560, 3, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_zero_all(input string tag);
        chk({tag, " active"}, int'(res_active), 0);
        chk({tag, " sleep"},  int'(res_sleep),  0);
        chk({tag, " lpi"},    int'(res_lpi),    0);
        chk({tag, " wake"},   int'(res_wake),   0);
        chk({tag, " drop"},   int'(drop_cnt),   0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        int cur;
        repeat (4) @(negedge clk);
        // R1: outputs held in reset
        chk("R1 state in reset", int'(state_code), 0);
        chk("R1 pwr_en in reset", int'(pwr_en), 1);
        rst = 1'b0;
        chk("R1 hold after reset", int'(traffic_hold), 0);
        chk_zero_all("R1 counters after reset");

        // Opening request with a clear on the same edge (R9 wins over R8)
        hdr_valid = 1'b1; hdr_sleep = 1'b1; stats_clr = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0; hdr_sleep = 1'b0; stats_clr = 1'b0;
        cur = 1;

        for (int i = 0; i < NV; i++) begin
            while (cur < VEC[i].k) begin
                @(negedge clk);
                hdr_valid = 1'b0; hdr_sleep = 1'b0;
                cur++;
            end
            chk($sformatf("R2 R3 R4 state k=%0d", cur), int'(state_code), int'(VEC[i].st));
            chk($sformatf("R6 pwr_en k=%0d", cur), int'(pwr_en), int'(VEC[i].pwr));
            chk($sformatf("R6 hold k=%0d", cur), int'(traffic_hold), int'(VEC[i].hold));
            chk($sformatf("R8 R9 res_active k=%0d", cur), int'(res_active), VEC[i].ac);
            chk($sformatf("R8 res_sleep k=%0d", cur), int'(res_sleep), VEC[i].sl);
            chk($sformatf("R8 res_lpi k=%0d", cur), int'(res_lpi), VEC[i].lp);
            chk($sformatf("R8 res_wake k=%0d", cur), int'(res_wake), VEC[i].wk);
            chk($sformatf("R7 drop k=%0d", cur), int'(drop_cnt), VEC[i].dr);
            if (VEC[i].req) begin
                hdr_valid = 1'b1; hdr_sleep = 1'b1;
            end
        end

        // R5: valid without flag is not a request
        @(negedge clk);
        hdr_valid = 1'b1; hdr_sleep = 1'b0;
        @(negedge clk);
        hdr_valid = 1'b0;
        chk("R5 valid alone", int'(state_code), 0);

        // R5: flag without valid is not a request
        hdr_sleep = 1'b1;
        @(negedge clk);
        hdr_sleep = 1'b0;
        chk("R5 flag alone", int'(state_code), 0);

        // R5: a proper request enters Sleep on the sampling edge
        hdr_valid = 1'b1; hdr_sleep = 1'b1;
        @(negedge clk);
        chk("R5 accepted", int'(state_code), 1);

        // R7: six more requests during Sleep saturate the 3-bit drop counter
        repeat (6) @(negedge clk);
        hdr_valid = 1'b0; hdr_sleep = 1'b0;
        chk("R7 drop saturates", int'(drop_cnt), 7);
        chk("R7 state unaffected", int'(state_code), 1);

        // R9: clear alone zeroes everything, then R8 counting resumes
        stats_clr = 1'b1;
        @(negedge clk);
        stats_clr = 1'b0;
        chk_zero_all("R9 clear");
        @(negedge clk);
        chk("R8 sleep after clear", int'(res_sleep), 1);
        chk("R8 active after clear", int'(res_active), 0);

        // R1: reset in the middle of an excursion
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 state mid reset", int'(state_code), 0);
        chk("R1 pwr_en mid reset", int'(pwr_en), 1);
        chk("R1 hold mid reset", int'(traffic_hold), 0);
        chk_zero_all("R1 counters mid reset");

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end
endmodule